// File: doc/BRIEF.md
# Masked Interrupt Status Register Set

This block gathers interrupt events from up to 32 sources into a status vector, filters them through a mask vector, and drives one level-sensitive interrupt line. It is reached over a plain 32-bit word register port with a word index, a write strobe with data, and a read strobe with combinational read data. A hardware event input per source sets the matching status bit. Software clears a bit by writing a one to it, and can also inject status bits through a trigger register.

The mask cannot be written as a whole. Software unmasks sources by writing ones to an enable strobe register, and masks them by writing ones to a disable strobe register. Bits listed in a reserved pattern are not implemented anywhere and always read as zero. The interrupt line is registered, so it follows the status and mask state one clock later.

Top module: `mirq_regs`

## Requirements
- R1: After reset, status reads 0x00000000, the mask reads 0x0003BFFF and `irq` is low.
- R2: A high bit on `events` sets the matching status bit for every implemented bit position. The bit stays set after the event goes away.
- R3: A write to the status register (word index 0) clears each status bit where the written word has a one, but only within 0x0003BFFF. Other status bits keep their value.
- R4: A write to the enable register (word index 2) clears each mask bit where the written word has a one. A read of index 2 returns zero.
- R5: A write to the disable register (word index 3) sets each mask bit where the written word has a one. A read of index 3 returns zero.
- R6: A write to the trigger register (word index 4) ORs the implemented written bits into status. A read of index 4 returns zero.
- R7: A write to the mask register (word index 1) leaves the mask unchanged. The mask is read at index 1.
- R8: Bits in the reserved pattern 0xFFC04000 are never set in status or mask, and they read as zero.
- R9: `irq` equals the OR over all bits of (status AND NOT mask), as that state stood before the previous rising clock edge. The line therefore changes one cycle after the state changes.
- R10: When an event and a status clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word index of the register accessed |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational, zero when idle |
| events | input | 32 | Per-source event inputs, active high |
| irq | output | 1 | Registered level interrupt |

## Verification
Single-bit sweeps over all 32 positions trigger, enable, disable and clear each bit in turn. They show whether each bit is implemented, clearable or reserved. They also catch a bit whose status and mask wiring has been swapped or shifted. The bench writes all ones to the event inputs and the clear register, and this pattern separates the bits that can be cleared from the implemented bits that cannot. An event and a clear on one bit in the same cycle checks which one wins. The interrupt line is compared with the bench model after every clocked access, and this shows whether its timing is off by a cycle or whether it ignores the mask.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
   typedef enum logic [2:0] {
      IX_STAT = 3'd0,
      IX_MASK = 3'd1,
      IX_EN   = 3'd2,
      IX_DIS  = 3'd3,
      IX_TRG  = 3'd4
   } reg_ix_e;

   typedef struct packed {
      logic clr;
      logic en;
      logic dis;
      logic trg;
   } wr_stb_t;
endpackage

// File: rtl/mirq_decode.sv
module mirq_decode
   import mirq_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output wr_stb_t           stb
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("mirq_decode: ADDR_W must be at least 3");
   end

   always_comb begin
      stb = '0;
      if (wr_en) begin
         unique case (addr)
            ADDR_W'(IX_STAT): stb.clr = 1'b1;
            ADDR_W'(IX_EN):   stb.en  = 1'b1;
            ADDR_W'(IX_DIS):  stb.dis = 1'b1;
            ADDR_W'(IX_TRG):  stb.trg = 1'b1;
            default:          stb     = '0;
         endcase
      end
   end
endmodule

// File: rtl/mirq_state.sv
module mirq_state
   import mirq_pkg::*;
#(
   parameter int           W         = 32,
   parameter logic [W-1:0] IMPL      = 32'h003F_BFFF,
   parameter logic [W-1:0] CLR_BITS  = 32'h0003_BFFF,
   parameter logic [W-1:0] MASK_INIT = 32'h0003_BFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  wr_stb_t      stb,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] events,
   output logic [W-1:0] status_q,
   output logic [W-1:0] mask_q
);
   logic [W-1:0] clr_v, set_v, en_v, dis_v, status_d, mask_d;

   always_comb begin
      clr_v    = stb.clr ? (wdata & CLR_BITS) : '0;
      set_v    = (stb.trg ? wdata : '0) | events;
      en_v     = stb.en  ? wdata : '0;
      dis_v    = stb.dis ? wdata : '0;
      // events are ORed in after the clear, so an event wins over a clear
      status_d = ((status_q & ~clr_v) | set_v) & IMPL;
      mask_d   = ((mask_q & ~en_v) | dis_v) & IMPL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= MASK_INIT;
      end else begin
         status_q <= status_d;
         mask_q   <= mask_d;
      end
   end

   // R3
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.clr |=> ((status_q & $past(wdata & CLR_BITS & ~events)) == '0));
   // R4
   en_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.en |=> ((mask_q & $past(wdata)) == '0));
   // R5
   dis_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.dis |=> ((mask_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));
   // R6
   trg_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.trg |=> ((status_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));
   // R10
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (events != '0) |=> ((status_q & $past(events & IMPL)) == $past(events & IMPL)));
endmodule

// File: rtl/mirq_out.sv
module mirq_out #(
   parameter int W       = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   input  logic [W-1:0] mask,
   output logic         irq
);
   logic pend;
   assign pend = |(status & ~mask);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq = irq_q;

      // R9
      irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((status & ~mask) == '0) |=> !irq);
      // R9
      irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((status & ~mask) != '0) |=> irq);
   end else begin : g_comb
      assign irq = pend;
   end
endmodule

// File: rtl/mirq_regs.sv
module mirq_regs
   import mirq_pkg::*;
#(
   parameter int            W         = 32,
   parameter int            ADDR_W    = 3,
   parameter logic [W-1:0]  RSVD_BITS = 32'hFFC0_4000,
   parameter logic [W-1:0]  CLR_BITS  = 32'h0003_BFFF,
   parameter logic [W-1:0]  MASK_INIT = 32'h0003_BFFF,
   parameter bit            REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              wr_en,
   input  logic [W-1:0]      wr_data,
   input  logic              rd_en,
   output logic [W-1:0]      rd_data,
   input  logic [W-1:0]      events,
   output logic              irq
);
   localparam logic [W-1:0] IMPL = ~RSVD_BITS;

   if ((CLR_BITS & RSVD_BITS) != '0) begin : g_bad_clr
      $error("mirq_regs: clearable bits overlap reserved bits");
   end
   if ((MASK_INIT & RSVD_BITS) != '0) begin : g_bad_init
      $error("mirq_regs: mask reset value sets reserved bits");
   end

   wr_stb_t      stb;
   logic [W-1:0] status_q, mask_q;

   mirq_decode #(.ADDR_W(ADDR_W)) i_dec (
      .wr_en (wr_en),
      .addr  (reg_addr),
      .stb   (stb)
   );

   mirq_state #(
      .W(W), .IMPL(IMPL), .CLR_BITS(CLR_BITS), .MASK_INIT(MASK_INIT)
   ) i_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (stb),
      .wdata    (wr_data),
      .events   (events),
      .status_q (status_q),
      .mask_q   (mask_q)
   );

   mirq_out #(.W(W), .REG_OUT(REG_OUT)) i_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_q),
      .mask   (mask_q),
      .irq    (irq)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (reg_addr == ADDR_W'(IX_STAT))      rd_data = status_q;
         else if (reg_addr == ADDR_W'(IX_MASK)) rd_data = mask_q;
      end
   end

   // R8
   rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & RSVD_BITS) == '0);
   // R4
   strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (reg_addr == ADDR_W'(IX_EN) || reg_addr == ADDR_W'(IX_DIS)
                 || reg_addr == ADDR_W'(IX_TRG))) |-> (rd_data == '0));
   // R7
   mask_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == ADDR_W'(IX_MASK)) |=> $stable(mask_q));
endmodule

// File: tb/test_mirq_regs.sv
module test_mirq_regs;
   localparam logic [31:0] RSVD = 32'hFFC0_4000;
   localparam logic [31:0] IMPL = ~RSVD;
   localparam logic [31:0] CLRB = 32'h0003_BFFF;
   localparam logic [31:0] MINI = 32'h0003_BFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [31:0] events = '0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [31:0] m_st, m_mk;

   always #2 clk = ~clk;

   mirq_regs i_mirq_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .events(events), .irq(irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] ix, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_en = 1'b1;
      reg_addr = ix;
      #1;
      chk(rd_data, exp, tag);
      rd_en = 1'b0;
   endtask

   // one clocked access; model follows the requirements, irq checked (R9)
   task automatic drive(input logic [2:0] ix, input logic we, input logic [31:0] wd,
                        input logic [31:0] ev);
      logic exp_irq;
      logic [31:0] nst, nmk;
      @(negedge clk);
      reg_addr = ix; wr_en = we; wr_data = wd; events = ev;
      @(posedge clk);
      exp_irq = |(m_st & ~m_mk);
      nst = m_st;
      nmk = m_mk;
      if (we && ix == 3'd0) nst = nst & ~(wd & CLRB);
      if (we && ix == 3'd4) nst = nst | wd;
      nst = (nst | ev) & IMPL;
      if (we && ix == 3'd2) nmk = nmk & ~wd;
      if (we && ix == 3'd3) nmk = nmk | wd;
      nmk = nmk & IMPL;
      m_st = nst;
      m_mk = nmk;
      #1;
      chk({31'd0, irq}, {31'd0, exp_irq}, "R9 irq");
      wr_en = 1'b0;
      events = '0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      m_st = '0;
      m_mk = MINI;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      chk({31'd0, irq}, 32'd0, "R1 irq");
      rd(3'd0, 32'd0, "R1 status");
      rd(3'd1, MINI, "R1 mask");
      // R4 R5 R6 strobe registers read zero
      rd(3'd2, 32'd0, "R4 enable read");
      rd(3'd3, 32'd0, "R5 disable read");
      rd(3'd4, 32'd0, "R6 trigger read");

      // per-bit sweep over all positions
      for (int b = 0; b < 32; b++) begin
         logic [31:0] one;
         one = 32'd1 << b;
         drive(3'd4, 1'b1, one, '0);              // R6 trigger
         rd(3'd0, m_st, (RSVD[b]) ? "R8 status reserved" : "R6 trigger");
         drive(3'd1, 1'b1, 32'hFFFF_FFFF, '0);    // R7 direct mask write
         rd(3'd1, m_mk, "R7 mask unchanged");
         drive(3'd2, 1'b1, one, '0);              // R4 enable
         rd(3'd1, m_mk, (RSVD[b]) ? "R8 mask reserved" : "R4 enable");
         drive(3'd0, 1'b0, '0, '0);               // idle, irq follows
         drive(3'd3, 1'b1, one, '0);              // R5 disable
         rd(3'd1, m_mk, "R5 disable");
         drive(3'd0, 1'b1, one, '0);              // R3 clear
         rd(3'd0, m_st, "R3 clear");
      end

      // R2 every event, then R3 clear all
      drive(3'd0, 1'b0, '0, 32'hFFFF_FFFF);
      rd(3'd0, IMPL, "R2 all events");
      drive(3'd0, 1'b0, '0, '0);
      rd(3'd0, IMPL, "R2 held");
      drive(3'd0, 1'b1, 32'hFFFF_FFFF, '0);
      rd(3'd0, IMPL & ~CLRB, "R3 non-clearable kept");

      // R10 event versus clear on bit 5
      drive(3'd0, 1'b1, 32'h0000_0020, 32'h0000_0020);
      rd(3'd0, (IMPL & ~CLRB) | 32'h20, "R10 event wins");

      // R9 explicit latency: unmask bit 0 with status bit 0 clear
      drive(3'd0, 1'b1, 32'h20, '0);
      drive(3'd3, 1'b1, 32'hFFFF_FFFF, '0);
      drive(3'd0, 1'b0, '0, '0);
      drive(3'd2, 1'b1, 32'h1, '0);
      drive(3'd4, 1'b1, 32'h1, '0);
      chk({31'd0, irq}, 32'd0, "R9 irq not yet");
      drive(3'd0, 1'b0, '0, '0);
      chk({31'd0, irq}, 32'd1, "R9 irq one cycle later");
      drive(3'd0, 1'b1, 32'h1, '0);
      drive(3'd0, 1'b0, '0, '0);
      chk({31'd0, irq}, 32'd0, "R9 irq drops");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule